// File: doc/BRIEF.md
# Coherence Miss Classifier

This block is a passive monitor for a write-invalidate multiprocessor model with multi-word cache blocks. Each cycle it may take one access made by one core: a core number, a word address and a read/write flag. It keeps its own picture of which cores hold each block. For every access it decides whether the access hits, misses because of true sharing, misses because of false sharing, or misses for another reason. The last class covers the first time a core touches a block. Data values are not modelled. Cache capacity is treated as unlimited, so a block leaves a core only through invalidation.

For each block and core the monitor stores a held bit, an ever-held bit, a per-word mask of words that other cores wrote since this core last fetched the block, and a per-word mask of words this core has touched since its last fetch. When a core misses on a block it lost to invalidation, the written-by-others mask shows whether the word it wants was really changed. A write to a block that other cores still hold is an upgrade. It counts as true sharing when some other holder has used that word, and as false sharing when none has. The class appears one cycle after the access strobe. Three saturating counters keep running totals of the three miss kinds.

The word address is split with the word-in-block index in the low bits and the block index above it. Typical use is beside a trace replay or a core-cluster model, to measure how much coherence traffic comes from variables that happen to share a block.

Top module: `coh_miss_classifier`

## Requirements
- R1: `res_valid` rises exactly one cycle after a cycle with `acc_valid` high, and stays low otherwise. `res_class` is encoded as 0 = hit, 1 = true-sharing miss, 2 = false-sharing miss, 3 = other miss.
- R2: The first access by a core to a block it has never held since reset is classed 3 (other), whether it is a read or a write.
- R3: A read of a block the core currently holds is a hit (0). A write to a held block that no other core holds is also a hit.
- R4: A write by any core to any word of a block removes that block from every other core that holds it, so the next access by each of those cores to the block is a miss (1 or 2).
- R5: An access to a block the core lost to invalidation is a true-sharing miss (1) if another core wrote the accessed word since this core's last fetch. Otherwise it is a false-sharing miss (2).
- R6: A write to a held block that at least one other core also holds is a true-sharing miss (1) if some other holder has accessed that word since its own last fetch. Otherwise it is a false-sharing miss (2). Either way it removes the block from the other holders.
- R7: After any miss the core holds the block again with its written-by-others record cleared, so writes seen before the refetch no longer affect later classes.
- R8: `cnt_true`, `cnt_false` and `cnt_other` each increase by one per result of their class, in the same edge that raises `res_valid`. Each stops at 65535 and never wraps.
- R9: The address is {block index, word index}, with the word index in the low 2 bits for 4-word blocks. Accesses to one block never change the class of accesses to another block.
- R10: While `rst` is high, and on the first cycle after it, `res_valid` is 0, all counters are 0 and no core holds any block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_core | input | 2 | Number of the core making the access |
| acc_addr | input | 6 | Word address: block index above, word in block in the low bits |
| acc_write | input | 1 | 1 = write, 0 = read |
| res_valid | output | 1 | Class result valid, one cycle after the strobe |
| res_class | output | 2 | 0 hit, 1 true-sharing miss, 2 false-sharing miss, 3 other miss |
| cnt_true | output | 16 | Saturating count of true-sharing misses |
| cnt_false | output | 16 | Saturating count of false-sharing misses |
| cnt_other | output | 16 | Saturating count of other misses |

## Verification
The following properties are checked every cycle:
- A result appears only after a strobe.
- The counters never wrap and move by at most one per edge.
- A held block never carries written-by-others marks and is always marked as ever held.
- A core that repeats a read of the same word, or that accesses a block right after writing it, gets a hit.

The finer splits between true and false sharing depend on the history of several cores. Only the bench's directed sequences can show them: the two-core shared-block interleaving, upgrades with and without another holder, three-reader invalidation, and the clearing of records after a refetch. Counter saturation is shown by a long true-sharing ping-pong.

// File: rtl/ccm_pkg.sv
`timescale 1ns/1ps
package ccm_pkg;

  typedef enum logic [1:0] {
    CLS_HIT   = 2'd0,
    CLS_TRUE  = 2'd1,
    CLS_FALSE = 2'd2,
    CLS_OTHER = 2'd3
  } miss_cls_e;

  localparam int unsigned NUM_CLS_CNT = 3;

endpackage

// File: rtl/ccm_state_ram.sv
`timescale 1ns/1ps
// Per-block coherence record store: one row per block, one write port,
// one combinational read port (maps onto distributed RAM).
module ccm_state_ram #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned ROW_W = 40,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [ROW_W-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [ROW_W-1:0] rdata
);

  logic [ROW_W-1:0] rows [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) rows[i] <= '0;
    end else if (we) begin
      rows[waddr] <= wdata;
    end
  end

  assign rdata = rows[raddr];

endmodule

// File: rtl/ccm_classify.sv
`timescale 1ns/1ps
// Combinational classification and next-record computation for one access.
module ccm_classify
  import ccm_pkg::*;
#(
  parameter int unsigned NCORES = 4,
  parameter int unsigned WPB    = 4,
  localparam int unsigned CORE_W = (NCORES > 1) ? $clog2(NCORES) : 1,
  localparam int unsigned OFF_W  = (WPB > 1) ? $clog2(WPB) : 1
) (
  input  logic [NCORES-1:0]          held_i,
  input  logic [NCORES-1:0]          seen_i,
  input  logic [NCORES-1:0][WPB-1:0] wmask_i,
  input  logic [NCORES-1:0][WPB-1:0] umask_i,
  input  logic [CORE_W-1:0]          core_i,
  input  logic [OFF_W-1:0]           word_i,
  input  logic                       wr_i,
  output miss_cls_e                  cls_o,
  output logic [NCORES-1:0]          held_o,
  output logic [NCORES-1:0]          seen_o,
  output logic [NCORES-1:0][WPB-1:0] wmask_o,
  output logic [NCORES-1:0][WPB-1:0] umask_o
);

  logic [WPB-1:0]    word_bit;
  logic [NCORES-1:0] self_bit;
  logic [NCORES-1:0] peers_held;
  logic              peer_used_word;
  logic              refetch;

  assign word_bit   = WPB'(1) << word_i;
  assign self_bit   = NCORES'(1) << core_i;
  assign peers_held = held_i & ~self_bit;
  assign refetch    = ~held_i[core_i];

  always_comb begin
    peer_used_word = 1'b0;
    for (int d = 0; d < NCORES; d++) begin
      if (peers_held[d] && umask_i[d][word_i]) peer_used_word = 1'b1;
    end
  end

  always_comb begin
    if (!seen_i[core_i]) begin
      cls_o = CLS_OTHER;
    end else if (held_i[core_i]) begin
      if (!wr_i || (peers_held == '0)) cls_o = CLS_HIT;
      else if (peer_used_word)         cls_o = CLS_TRUE;
      else                             cls_o = CLS_FALSE;
    end else begin
      cls_o = wmask_i[core_i][word_i] ? CLS_TRUE : CLS_FALSE;
    end
  end

  always_comb begin
    held_o  = held_i;
    seen_o  = seen_i;
    wmask_o = wmask_i;
    umask_o = umask_i;
    for (int d = 0; d < NCORES; d++) begin
      if (self_bit[d]) begin
        held_o[d] = 1'b1;
        seen_o[d] = 1'b1;
        if (refetch) begin
          wmask_o[d] = '0;
          umask_o[d] = word_bit;
        end else begin
          umask_o[d] = umask_i[d] | word_bit;
        end
      end else if (wr_i) begin
        held_o[d]  = 1'b0;
        wmask_o[d] = wmask_i[d] | word_bit;
      end
    end
  end

endmodule

// File: rtl/ccm_sat_counter.sv
`timescale 1ns/1ps
module ccm_sat_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst)                      count <= '0;
    else if (inc && count != '1)  count <= count + W'(1);
  end

  // R8
  cnt_hold_at_max_chk: assert property (@(posedge clk) disable iff (rst)
    (count == '1) |=> (count == '1));

  // R8
  cnt_step_of_one_chk: assert property (@(posedge clk) disable iff (rst)
    (count != $past(count)) |-> (count == $past(count) + W'(1)));

endmodule

// File: rtl/coh_miss_classifier.sv
`timescale 1ns/1ps
module coh_miss_classifier
  import ccm_pkg::*;
#(
  parameter int unsigned NCORES  = 4,
  parameter int unsigned NBLOCKS = 16,
  parameter int unsigned WPB     = 4,
  parameter int unsigned CNT_W   = 16,
  localparam int unsigned CORE_W = (NCORES > 1) ? $clog2(NCORES) : 1,
  localparam int unsigned OFF_W  = (WPB > 1) ? $clog2(WPB) : 1,
  localparam int unsigned BLK_W  = (NBLOCKS > 1) ? $clog2(NBLOCKS) : 1,
  localparam int unsigned ADDR_W = BLK_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [CORE_W-1:0] acc_core,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic              res_valid,
  output logic [1:0]        res_class,
  output logic [CNT_W-1:0]  cnt_true,
  output logic [CNT_W-1:0]  cnt_false,
  output logic [CNT_W-1:0]  cnt_other
);

  localparam int unsigned MASKS_W = NCORES * WPB;
  localparam int unsigned ROW_W   = 2 * NCORES + 2 * MASKS_W;

  logic [BLK_W-1:0] blk;
  logic [OFF_W-1:0] word;
  assign blk  = acc_addr[ADDR_W-1:OFF_W];
  assign word = acc_addr[OFF_W-1:0];

  logic [ROW_W-1:0] rd_row, wr_row;

  logic [NCORES-1:0]          cur_held, cur_seen, nxt_held, nxt_seen;
  logic [NCORES-1:0][WPB-1:0] cur_wmask, cur_umask, nxt_wmask, nxt_umask;

  assign {cur_held, cur_seen, cur_wmask, cur_umask} = rd_row;
  assign wr_row = {nxt_held, nxt_seen, nxt_wmask, nxt_umask};

  ccm_state_ram #(.DEPTH(NBLOCKS), .ROW_W(ROW_W)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (acc_valid),
    .waddr (blk),
    .wdata (wr_row),
    .raddr (blk),
    .rdata (rd_row)
  );

  miss_cls_e cls;

  ccm_classify #(.NCORES(NCORES), .WPB(WPB)) u_cls (
    .held_i  (cur_held),
    .seen_i  (cur_seen),
    .wmask_i (cur_wmask),
    .umask_i (cur_umask),
    .core_i  (acc_core),
    .word_i  (word),
    .wr_i    (acc_write),
    .cls_o   (cls),
    .held_o  (nxt_held),
    .seen_o  (nxt_seen),
    .wmask_o (nxt_wmask),
    .umask_o (nxt_umask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_class <= 2'd0;
    end else begin
      res_valid <= acc_valid;
      if (acc_valid) res_class <= cls;
    end
  end

  logic [NUM_CLS_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0]       cnt_val [NUM_CLS_CNT];

  assign cnt_inc[0] = acc_valid && (cls == CLS_TRUE);
  assign cnt_inc[1] = acc_valid && (cls == CLS_FALSE);
  assign cnt_inc[2] = acc_valid && (cls == CLS_OTHER);

  for (genvar g = 0; g < NUM_CLS_CNT; g++) begin : g_cnt
    ccm_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (cnt_inc[g]),
      .count (cnt_val[g])
    );
  end

  assign cnt_true  = cnt_val[0];
  assign cnt_false = cnt_val[1];
  assign cnt_other = cnt_val[2];

  // ---------------- assertions ----------------
  logic [NCORES-1:0] held_but_dirty;
  always_comb begin
    for (int d = 0; d < NCORES; d++) held_but_dirty[d] = cur_held[d] && (cur_wmask[d] != '0);
  end

  // R1
  res_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(acc_valid));

  // R1
  no_strobe_no_res_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !res_valid);

  // R7
  held_row_clean_chk: assert property (@(posedge clk) disable iff (rst)
    held_but_dirty == '0);

  // R2
  held_implies_seen_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_held & ~cur_seen) == '0);

  // R3
  reread_is_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write && !$past(rst) && $past(acc_valid) && !$past(acc_write)
     && acc_core == $past(acc_core) && acc_addr == $past(acc_addr))
    |=> (res_class == CLS_HIT));

  // R3
  after_own_write_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !$past(rst) && $past(acc_valid) && $past(acc_write)
     && acc_core == $past(acc_core) && blk == $past(blk))
    |=> (res_class == CLS_HIT));

endmodule

// File: tb/sim_coh_miss_classifier.sv
`timescale 1ns/1ps
module sim_coh_miss_classifier;

  localparam logic [1:0] HIT = 2'd0, TRU = 2'd1, FLS = 2'd2, OTH = 2'd3;
  localparam int unsigned SAT = 65535;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_core = '0;
  logic [5:0]  acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        res_valid;
  logic [1:0]  res_class;
  logic [15:0] cnt_true, cnt_false, cnt_other;

  always #10 clk = ~clk;

  coh_miss_classifier u0 (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_core(acc_core),
    .acc_addr(acc_addr), .acc_write(acc_write), .res_valid(res_valid),
    .res_class(res_class), .cnt_true(cnt_true), .cnt_false(cnt_false),
    .cnt_other(cnt_other)
  );

  typedef struct {
    logic [1:0] cls;
    string      tag;
  } exp_t;

  exp_t sbq[$];
  int unsigned n_checks = 0, n_fails = 0;
  int unsigned e_true = 0, e_false = 0, e_other = 0;

  task automatic check(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic access(input int c, input int a, input bit w, input logic [1:0] e, input string tag);
    exp_t it;
    @(negedge clk);
    acc_valid = 1'b1;
    acc_core  = 2'(c);
    acc_addr  = 6'(a);
    acc_write = w;
    it.cls = e;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  // Monitor: pops expected items as results appear.
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R1 unexpected result", 1, 0);
      end else begin
        exp_t it;
        it = sbq.pop_front();
        check(res_class == it.cls, it.tag, res_class, it.cls);
        if (it.cls == TRU && e_true  < SAT) e_true++;
        if (it.cls == FLS && e_false < SAT) e_false++;
        if (it.cls == OTH && e_other < SAT) e_other++;
        check(cnt_true  == e_true,  "R8 cnt_true",  cnt_true,  e_true);
        check(cnt_false == e_false, "R8 cnt_false", cnt_false, e_false);
        check(cnt_other == e_other, "R8 cnt_other", cnt_other, e_other);
      end
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0, "R10 res_valid in reset", res_valid, 0);
    check(cnt_true == 0 && cnt_false == 0 && cnt_other == 0, "R10 counters in reset",
          cnt_true + cnt_false + cnt_other, 0);
    rst = 1'b0;
    @(negedge clk);
    check(res_valid == 1'b0, "R10 res_valid after reset", res_valid, 0);

    // Two-core shared block 2: x1 = word 0 (addr 8), x2 = word 1 (addr 9)
    access(0, 8,  0, OTH, "R2 cold read c0");
    access(0, 9,  0, HIT, "R3 read hit c0");
    access(1, 8,  0, OTH, "R2 cold read c1");
    access(1, 9,  0, HIT, "R3 read hit c1");
    access(0, 8,  1, TRU, "R6 upgrade, peer used word");
    access(1, 9,  0, FLS, "R5 other word written");
    access(0, 8,  1, FLS, "R6 upgrade, peer did not use word");
    access(1, 9,  1, FLS, "R5 write miss, word untouched");
    access(0, 9,  0, TRU, "R5 accessed word written by peer");
    access(1, 9,  1, TRU, "R6 upgrade, peer read word");
    access(1, 10, 1, HIT, "R3 write hit, sole holder");
    access(1, 10, 0, HIT, "R3 read after own write");
    access(0, 10, 0, TRU, "R5 word 2 written by peer");
    access(1, 11, 1, FLS, "R6 upgrade, word 3 unused by peer");
    access(0, 9,  0, FLS, "R7 stale mark cleared by refetch");

    // Independent blocks 5 and 6
    access(2, 20, 0, OTH, "R9 cold read block 5");
    access(3, 24, 1, OTH, "R2 cold write block 6");
    access(2, 20, 0, HIT, "R9 other block write no effect");
    access(3, 25, 1, HIT, "R9 write hit block 6");

    // Three readers of block 7, then one writer
    access(0, 28, 0, OTH, "R2 cold c0 block 7");
    access(1, 28, 0, OTH, "R2 cold c1 block 7");
    access(2, 28, 0, OTH, "R2 cold c2 block 7");
    access(3, 31, 1, OTH, "R4 cold write invalidates all");
    access(0, 28, 0, FLS, "R4 c0 lost copy, word 0 clean");
    access(1, 31, 0, TRU, "R4 c1 lost copy, word 3 written");
    access(2, 29, 1, FLS, "R4 c2 lost copy, write word 1");
    access(3, 29, 0, TRU, "R4 writer lost copy to c2");
    idle();
    @(negedge clk);
    @(negedge clk);
    check(res_valid == 1'b0, "R1 no result without strobe", res_valid, 0);

    // Ping-pong writes to block 0 word 0 to saturate the true counter
    for (int i = 0; i < 65540; i++)
      access(i % 2, 0, 1, (i < 2) ? OTH : TRU, "R8 ping-pong class");
    idle();
    wait (sbq.size() == 0);
    @(negedge clk);
    check(cnt_true == 16'd65535, "R8 saturated true counter", cnt_true, SAT);
    check(res_valid == 1'b0, "R1 idle after burst", res_valid, 0);

    summary();
    $finish;
  end

endmodule